// File: doc/BRIEF.md
# Burst Address Counter with Load, Hold and Zeroing

This block produces the internal address for one port of a synchronous memory. On every clock cycle it picks one of four sources for that address: zero, a freshly presented external address, the previous internal address plus one, or the previous internal address unchanged. The picked value goes to the array in the same cycle. The block also keeps the value so that later cycles can step through a burst or stay on one location without the external address being driven again.

Three active-low controls choose the source, in a fixed priority. The zeroing control has the highest priority. The load strobe comes next and the count enable comes last. The block has no chip-select or byte-select inputs. This is deliberate: loads and increments take place in every cycle where their control is asserted, whether or not the surrounding memory is selected. The address width is a parameter. A memory with 16K words uses 14 bits and one with 32K words uses 15 bits. No data flows through the block, so its pins are plain control and address signals with no handshake. A synchronous reset clears the stored address at power-up.

Top module: `burst_addr_counter`

## Requirements
- R1: When `cnt_rst_n` is low, `cur_addr` is 0 in that cycle, whatever `strobe_n`, `cnt_en_n` and `ext_addr` are.
- R2: When `cnt_rst_n` is high and `strobe_n` is low, `cur_addr` equals `ext_addr` in that cycle, and that value becomes the stored address.
- R3: When `cnt_rst_n` and `strobe_n` are high and `cnt_en_n` is low, `cur_addr` is the previous cycle's `cur_addr` plus one.
- R4: When all three controls are high, `cur_addr` repeats the previous cycle's value, and changes on `ext_addr` have no effect on it.
- R5: Each selected address appears on `cur_addr` in the cycle its controls are applied. There is no cycle of latency between the controls and the address.
- R6: Incrementing from the all-ones address gives 0.
- R7: After the synchronous `rst`, the stored address is 0, so a hold cycle presents address 0.
- R8: The zero selected in a zeroing cycle is stored. An increment in the following cycle therefore presents 1, with no dead cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high power-up reset of the stored address |
| ext_addr | input | ADDR_W | External address, taken when the load strobe is low |
| strobe_n | input | 1 | Active-low load strobe |
| cnt_en_n | input | 1 | Active-low count enable |
| cnt_rst_n | input | 1 | Active-low counter zeroing, highest priority |
| cur_addr | output | ADDR_W | Internal address used in the current cycle |

## Verification
The bench builds the counter with `ADDR_W` = 4. With only 16 addresses, a short run of increments reaches the all-ones value, so the wrap to zero is exercised many times during random traffic, not just once. Random mixes of the three controls, some biased toward long count runs, are compared against a priority model on every cycle. Directed sequences cover zeroing followed by counting, loading while counting, and holding while `ext_addr` changes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Source of the address presented in the current cycle
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_INC  = 2'd2,
    SRC_HOLD = 2'd3
  } addr_src_e;

endpackage

// File: rtl/addr_src_decode.sv
module addr_src_decode
  import burst_addr_pkg::*;
(
  input  logic      cnt_rst_n,
  input  logic      strobe_n,
  input  logic      cnt_en_n,
  output addr_src_e src
);

  // Priority: zeroing, then load, then count, then hold
  always_comb begin
    if (!cnt_rst_n)     src = SRC_ZERO;
    else if (!strobe_n) src = SRC_EXT;
    else if (!cnt_en_n) src = SRC_INC;
    else                src = SRC_HOLD;
  end

endmodule

// File: rtl/addr_src_mux.sv
module addr_src_mux
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  addr_src_e         src,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] held,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] bumped;

  // Natural modulo-2^ADDR_W increment wraps all-ones to zero
  assign bumped = held + ONE;

  always_comb begin
    unique case (src)
      SRC_ZERO: addr = '0;
      SRC_EXT:  addr = ext_addr;
      SRC_INC:  addr = bumped;
      default:  addr = held;
    endcase
  end

endmodule

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R7: power-up reset leaves the stored address at zero
  p_clear_on_reset_r7: assert property (@(posedge clk) rst |=> q == '0)
    else $error("stored address not cleared by reset");

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              cnt_en_n,
  input  logic              cnt_rst_n,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  addr_src_e         src;
  logic [ADDR_W-1:0] held;

  addr_src_decode u_decode (
    .cnt_rst_n (cnt_rst_n),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .src       (src)
  );

  addr_src_mux #(.ADDR_W(ADDR_W)) u_mux (
    .src      (src),
    .ext_addr (ext_addr),
    .held     (held),
    .addr     (cur_addr)
  );

  // The address used this cycle is the one remembered for the next
  addr_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
    .clk (clk),
    .rst (rst),
    .d   (cur_addr),
    .q   (held)
  );

  // Set once the previous cycle lay outside reset, so $past refers to a live cycle
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R1: zeroing wins over everything
  p_zero_priority_r1: assert property (@(posedge clk) disable iff (rst)
    !cnt_rst_n |-> cur_addr == '0)
    else $error("zeroing cycle did not present address 0");

  // R2: load passes the external address straight through
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_rst_n && !strobe_n) |-> cur_addr == ext_addr)
    else $error("load cycle did not present external address");

  // R3: count step is previous address plus one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_rst_n && strobe_n && !cnt_en_n) |->
      cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1)))
    else $error("count cycle did not advance by one");

  // R4: hold repeats the previous address
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_rst_n && strobe_n && cnt_en_n) |-> cur_addr == $past(cur_addr))
    else $error("hold cycle changed the address");

  // R6: stepping from all-ones wraps to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (live && cnt_rst_n && strobe_n && !cnt_en_n && $past(cur_addr) == TOP_ADDR)
      |-> cur_addr == '0)
    else $error("count did not wrap to zero");

  // R8: a step right after zeroing yields one
  p_step_after_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!cnt_rst_n) && cnt_rst_n && strobe_n && !cnt_en_n)
      |-> cur_addr == ADDR_W'(1))
    else $error("step after zeroing did not give 1");

endmodule

// File: tb/burst_addr_counter_test.sv
module burst_addr_counter_test;

  localparam int AW = 4;
  localparam int SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          strobe_n;
  logic          cnt_en_n;
  logic          cnt_rst_n;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int errors = 0;
  int model_held = 0;

  always #2 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) uut (
    .clk       (clk),
    .rst       (rst),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_rst_n (cnt_rst_n),
    .cur_addr  (cur_addr)
  );

  // One cycle: drive at the falling edge, check before the rising edge, update the model.
  // R5: the expected value is the one for the cycle just driven.
  task automatic step(input logic r_n, input logic s_n, input logic e_n,
                      input int a, input string extra);
    int exp;
    string req;
    @(negedge clk);
    cnt_rst_n = r_n;
    strobe_n  = s_n;
    cnt_en_n  = e_n;
    ext_addr  = AW'(a);
    #1;
    if (!r_n) begin
      exp = 0;
      req = "R1";
    end else if (!s_n) begin
      exp = a % SPAN;
      req = "R2";
    end else if (!e_n) begin
      exp = (model_held + 1) % SPAN;
      req = (model_held == SPAN - 1) ? "R6" : "R3";
    end else begin
      exp = model_held;
      req = "R4";
    end
    checks++;
    if (int'(cur_addr) != exp) begin
      errors++;
      $display("FAIL %s%s: cur_addr=%0d expected=%0d", req, extra, cur_addr, exp);
    end
    model_held = exp;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cnt_rst_n = 1'b1;
    strobe_n = 1'b1;
    cnt_en_n = 1'b1;
    ext_addr = '0;
    repeat (3) @(posedge clk);
    // Release reset while the controls request a load, which stores 9
    @(negedge clk);
    ext_addr = AW'(9);
    strobe_n = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strobe_n = 1'b1;
    model_held = 9;

    // Power-up state: reset, then hold, must present zero
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_held = 0;
    step(1, 1, 1, 7, " R7 reset state");

    // Load, then count through the top, wrapping to zero
    step(1, 0, 1, 13, " R5 load");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, " R5 count");
    // Hold while the external address changes: no effect
    step(1, 1, 1, 5, " hold ignores ext");
    step(1, 1, 1, 10, " hold ignores ext");
    // Zeroing overrides a load, then a count gives 1
    step(0, 0, 0, 11, " over load");
    step(1, 1, 0, 3, " R8 step after zero");
    step(1, 1, 0, 3, " R8 second step");
    // Load overrides count
    step(1, 0, 0, 15, " load over count");
    step(1, 1, 0, 0, " wrap after load");

    // Random traffic, biased toward counting
    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = $urandom_range(0, 15);
      step(pick != 0, pick > 3, pick > 10, $urandom_range(0, SPAN - 1), " random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule